// File: doc/BRIEF.md
# Sectored Direct-Mapped Data Cache

This block is a small write-through data cache in which each address tag owns a whole 64-byte block, while a separate valid bit is kept for each of the four 16-byte sectors inside that block. A tag miss allocates the block and refills all sixteen words from a word-serial memory port. A tag hit on a sector whose valid bit is clear fetches only that sector's four words, and the block stays where it is.

Two side ports act on validity alone. A snoop port takes the address of a write made elsewhere and clears the valid bit of the one sector that holds it, keeping the tag and the neighbouring sectors. A peer-fill port lets another cache hand over single sectors, so a block can become resident with only part of its sectors valid. Writes from the CPU always go to memory and never allocate. They update the cached copy only when the target sector is valid.

Top module: `sect_cache`

## Requirements
- R1: After reset every tag and sector is invalid, `cpu_ready` and `mem_valid` are low while nothing is requested, `pf_ready` is high, and the first read of any address returns `cpu_hit`=0.
- R2: A read whose tag matches and whose sector is valid completes in the same cycle with `cpu_ready`=1, `cpu_hit`=1 and the stored word, without any memory beat.
- R3: A read whose tag misses allocates the block and reads its 16 words from memory in ascending address order, starting at the block base, one word per beat where `mem_valid` and `mem_ready` are both high. The requested word is then returned with `cpu_hit`=0, and all four sectors are valid afterwards.
- R4: A snoop clears the valid bit only of the sector containing `sn_addr`. Later reads of other sectors of that block still hit, and the tag is kept.
- R5: A read whose tag matches but whose sector is invalid reads only that sector's 4 words from memory, returns `cpu_hit`=0, and leaves the other sectors' contents unchanged.
- R6: A peer fill writes the 4 words of one sector and marks that sector valid. If the set held another tag (or none), the block is reallocated with all its other sectors invalid, so reads of those sectors are sector misses of 4 beats. Lane i of `pf_data` (bits 32*i+31 down to 32*i) is the word at sector offset 4*i bytes.
- R7: A snoop to a sector of the block being refilled, arriving before that sector's last word, leaves that sector invalid when the refill ends, so the next read of it is a sector miss.
- R8: While a miss is serviced `cpu_ready` stays low. A beat takes place only in a cycle where `mem_ready` is high, and the beat address only advances after an accepted beat.
- R9: A CPU write issues exactly one memory write beat with `mem_we`=1 and completes when memory accepts it. If the sector is valid the cached word is updated and `cpu_hit`=1. Otherwise nothing is allocated and `cpu_hit`=0.
- R10: Byte addresses split into byte-in-word [1:0], word-in-sector [3:2], sector [5:4], set [9:6] and tag [31:10]. The cache is direct-mapped, so a miss to another tag in the same set replaces the block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | CPU byte address |
| cpu_wdata | input | 32 | CPU write data |
| cpu_ready | output | 1 | Access completes in this cycle |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ready` on a read |
| cpu_hit | output | 1 | Access found a valid sector, valid with `cpu_ready` |
| mem_valid | output | 1 | Memory beat request |
| mem_we | output | 1 | Memory beat is a write |
| mem_addr | output | 32 | Memory byte address of the beat |
| mem_wdata | output | 32 | Memory write word |
| mem_ready | input | 1 | Memory accepts the beat this cycle |
| mem_rdata | input | 32 | Read word for the accepted beat |
| sn_valid | input | 1 | Snoop invalidate strobe |
| sn_addr | input | 32 | Byte address written elsewhere |
| pf_valid | input | 1 | Peer sector fill strobe |
| pf_ready | output | 1 | Peer fill is taken this cycle |
| pf_addr | input | 32 | Byte address inside the filled sector |
| pf_data | input | 128 | Four words of the sector, lowest word in bits 31:0 |

## Verification
Reads are tried against an empty set, a fully valid block, a block with one snooped sector, a block that a peer filled only in part, and a set that a different tag has taken over. Comparing beat counts of 16, 4 and 0 separates a block refill, a sector refill and a hit. Writes are aimed at a valid sector and at an absent block, which shows whether the cached copy is updated and whether a write wrongly allocates. A snoop issued in the middle of a refill and a memory port that stalls every other cycle probe the ordering corners.

// File: rtl/sect_cache_pkg.sv
`timescale 1ns/1ps
package sect_cache_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FILL  = 2'd1,
        ST_WRITE = 2'd2,
        ST_RESP  = 2'd3
    } sc_state_e;

endpackage

// File: rtl/sect_addr_split.sv
`timescale 1ns/1ps
module sect_addr_split #(
    parameter int ADDR_W = 32,
    parameter int WB     = 2,
    parameter int SWB    = 2,
    parameter int SB     = 2,
    parameter int IB     = 4,
    localparam int TAG_W = ADDR_W - IB - SB - SWB - WB
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tag,
    output logic [IB-1:0]     set,
    output logic [SB-1:0]     sec,
    output logic [SWB-1:0]    wrd
);
    logic unused_bits;

    assign wrd = addr[WB +: SWB];
    assign sec = addr[WB + SWB +: SB];
    assign set = addr[WB + SWB + SB +: IB];
    assign tag = addr[ADDR_W-1 -: TAG_W];
    assign unused_bits = ^addr[WB-1:0];
endmodule

// File: rtl/sect_data_ram.sv
`timescale 1ns/1ps
module sect_data_ram #(
    parameter int WORD_W     = 32,
    parameter int SETS       = 16,
    parameter int SECTORS    = 4,
    parameter int SECT_WORDS = 4,
    localparam int IB   = $clog2(SETS),
    localparam int SB   = $clog2(SECTORS),
    localparam int SWB  = $clog2(SECT_WORDS),
    localparam int ROWS = SETS * SECTORS
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [IB-1:0]                wset,
    input  logic [SB-1:0]                wsec,
    input  logic [SECT_WORDS-1:0]        wmask,
    input  logic [SECT_WORDS*WORD_W-1:0] wdata,
    input  logic [IB-1:0]                rset,
    input  logic [SB-1:0]                rsec,
    input  logic [SWB-1:0]               rwrd,
    output logic [WORD_W-1:0]            rdata
);
    logic [WORD_W-1:0] rd_lane [SECT_WORDS];

    for (genvar w = 0; w < SECT_WORDS; w++) begin : g_lane
        logic [WORD_W-1:0] lane_q [ROWS];

        always_ff @(posedge clk) begin
            if (we && wmask[w]) begin
                lane_q[{wset, wsec}] <= wdata[w*WORD_W +: WORD_W];
            end
        end

        assign rd_lane[w] = lane_q[{rset, rsec}];
    end

    assign rdata = rd_lane[rwrd];
endmodule

// File: rtl/sect_cache.sv
`timescale 1ns/1ps
module sect_cache
    import sect_cache_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_W     = 32,
    parameter int SETS       = 16,
    parameter int SECTORS    = 4,
    parameter int SECT_WORDS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_req,
    input  logic                         cpu_we,
    input  logic [ADDR_W-1:0]            cpu_addr,
    input  logic [WORD_W-1:0]            cpu_wdata,
    output logic                         cpu_ready,
    output logic [WORD_W-1:0]            cpu_rdata,
    output logic                         cpu_hit,
    output logic                         mem_valid,
    output logic                         mem_we,
    output logic [ADDR_W-1:0]            mem_addr,
    output logic [WORD_W-1:0]            mem_wdata,
    input  logic                         mem_ready,
    input  logic [WORD_W-1:0]            mem_rdata,
    input  logic                         sn_valid,
    input  logic [ADDR_W-1:0]            sn_addr,
    input  logic                         pf_valid,
    output logic                         pf_ready,
    input  logic [ADDR_W-1:0]            pf_addr,
    input  logic [SECT_WORDS*WORD_W-1:0] pf_data
);
    localparam int WB     = $clog2(WORD_W / 8);
    localparam int SWB    = $clog2(SECT_WORDS);
    localparam int SB     = $clog2(SECTORS);
    localparam int IB     = $clog2(SETS);
    localparam int FW     = SB + SWB;
    localparam int TAG_W  = ADDR_W - IB - FW - WB;
    localparam int NPORT  = 3;  // cpu, snoop, peer

    typedef struct packed {
        sc_state_e                      st;
        logic [SETS-1:0][TAG_W-1:0]     tag;
        logic [SETS-1:0]                tag_ok;
        logic [SETS-1:0][SECTORS-1:0]   vld;
        logic [SECTORS-1:0]             kill;
        logic [IB-1:0]                  fset;
        logic [TAG_W-1:0]               ftag;
        logic [FW-1:0]                  fword;
        logic [FW-1:0]                  fend;
        logic [WORD_W-1:0]              resp;
    } state_t;

    state_t q, d;

    // ---------------- address decoding for the three address ports
    logic [NPORT-1:0][ADDR_W-1:0] dec_addr;
    logic [NPORT-1:0][TAG_W-1:0]  dec_tag;
    logic [NPORT-1:0][IB-1:0]     dec_set;
    logic [NPORT-1:0][SB-1:0]     dec_sec;
    logic [NPORT-1:0][SWB-1:0]    dec_wrd;

    assign dec_addr = {pf_addr, sn_addr, cpu_addr};

    for (genvar p = 0; p < NPORT; p++) begin : g_dec
        sect_addr_split #(
            .ADDR_W(ADDR_W), .WB(WB), .SWB(SWB), .SB(SB), .IB(IB)
        ) u_split (
            .addr(dec_addr[p]),
            .tag (dec_tag[p]),
            .set (dec_set[p]),
            .sec (dec_sec[p]),
            .wrd (dec_wrd[p])
        );
    end

    logic [TAG_W-1:0] c_tag, s_tag, p_tag;
    logic [IB-1:0]    c_set, s_set, p_set;
    logic [SB-1:0]    c_sec, s_sec, p_sec;
    logic [SWB-1:0]   c_wrd;
    logic             unused_bits;

    assign {c_tag, c_set, c_sec, c_wrd} = {dec_tag[0], dec_set[0], dec_sec[0], dec_wrd[0]};
    assign {s_tag, s_set, s_sec}        = {dec_tag[1], dec_set[1], dec_sec[1]};
    assign {p_tag, p_set, p_sec}        = {dec_tag[2], dec_set[2], dec_sec[2]};
    assign unused_bits = ^{dec_wrd[1], dec_wrd[2]};

    logic c_tag_hit, c_hit, p_tag_hit, s_tag_hit;
    assign c_tag_hit = q.tag_ok[c_set] && (q.tag[c_set] == c_tag);
    assign c_hit     = c_tag_hit && q.vld[c_set][c_sec];
    assign p_tag_hit = q.tag_ok[p_set] && (q.tag[p_set] == p_tag);
    assign s_tag_hit = q.tag_ok[s_set] && (q.tag[s_set] == s_tag);

    // ---------------- data storage
    logic                         ram_we;
    logic [IB-1:0]                ram_wset;
    logic [SB-1:0]                ram_wsec;
    logic [SECT_WORDS-1:0]        ram_wmask;
    logic [SECT_WORDS*WORD_W-1:0] ram_wdata;
    logic [WORD_W-1:0]            ram_rdata;

    sect_data_ram #(
        .WORD_W(WORD_W), .SETS(SETS), .SECTORS(SECTORS), .SECT_WORDS(SECT_WORDS)
    ) u_ram (
        .clk  (clk),
        .we   (ram_we),
        .wset (ram_wset),
        .wsec (ram_wsec),
        .wmask(ram_wmask),
        .wdata(ram_wdata),
        .rset (c_set),
        .rsec (c_sec),
        .rwrd (c_wrd),
        .rdata(ram_rdata)
    );

    // ---------------- next-state logic
    logic [SB-1:0]  f_sec;
    logic [SWB-1:0] f_wrd;
    assign f_sec = q.fword[FW-1 -: SB];
    assign f_wrd = q.fword[SWB-1:0];

    always_comb begin
        d         = q;
        cpu_ready = 1'b0;
        cpu_rdata = '0;
        cpu_hit   = 1'b0;
        mem_valid = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        pf_ready  = 1'b0;
        ram_we    = 1'b0;
        ram_wset  = c_set;
        ram_wsec  = c_sec;
        ram_wmask = '0;
        ram_wdata = {SECT_WORDS{cpu_wdata}};

        unique case (q.st)
            ST_IDLE: begin
                pf_ready = 1'b1;
                if (pf_valid) begin
                    if (!p_tag_hit) begin
                        d.tag[p_set]    = p_tag;
                        d.tag_ok[p_set] = 1'b1;
                        d.vld[p_set]    = '0;
                    end
                    d.vld[p_set][p_sec] = 1'b1;
                    ram_we    = 1'b1;
                    ram_wset  = p_set;
                    ram_wsec  = p_sec;
                    ram_wmask = '1;
                    ram_wdata = pf_data;
                end else if (cpu_req && !cpu_we) begin
                    if (c_hit) begin
                        cpu_ready = 1'b1;
                        cpu_hit   = 1'b1;
                        cpu_rdata = ram_rdata;
                    end else begin
                        d.st   = ST_FILL;
                        d.fset = c_set;
                        d.ftag = c_tag;
                        d.kill = '0;
                        if (c_tag_hit) begin
                            d.fword = {c_sec, {SWB{1'b0}}};
                            d.fend  = {c_sec, {SWB{1'b1}}};
                        end else begin
                            d.tag[c_set]    = c_tag;
                            d.tag_ok[c_set] = 1'b1;
                            d.vld[c_set]    = '0;
                            d.fword         = '0;
                            d.fend          = '1;
                        end
                    end
                end else if (cpu_req) begin
                    d.st = ST_WRITE;
                end
            end

            ST_FILL: begin
                mem_valid = 1'b1;
                mem_addr  = {q.ftag, q.fset, q.fword, {WB{1'b0}}};
                if (mem_ready) begin
                    ram_we    = 1'b1;
                    ram_wset  = q.fset;
                    ram_wsec  = f_sec;
                    ram_wmask = SECT_WORDS'(1) << f_wrd;
                    ram_wdata = {SECT_WORDS{mem_rdata}};
                    if (f_sec == c_sec && f_wrd == c_wrd) begin
                        d.resp = mem_rdata;
                    end
                    if (f_wrd == {SWB{1'b1}}) begin
                        d.vld[q.fset][f_sec] = !q.kill[f_sec];
                    end
                    if (q.fword == q.fend) begin
                        d.st = ST_RESP;
                    end else begin
                        d.fword = q.fword + FW'(1);
                    end
                end
            end

            ST_WRITE: begin
                mem_valid = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = cpu_addr;
                mem_wdata = cpu_wdata;
                if (mem_ready) begin
                    cpu_ready = 1'b1;
                    d.st      = ST_IDLE;
                    if (c_hit) begin
                        cpu_hit   = 1'b1;
                        ram_we    = 1'b1;
                        ram_wmask = SECT_WORDS'(1) << c_wrd;
                    end
                end
            end

            ST_RESP: begin
                cpu_ready = 1'b1;
                cpu_rdata = q.resp;
                d.st      = ST_IDLE;
            end

            default: d.st = ST_IDLE;
        endcase

        // snoop is applied last so it wins over a fill in the same cycle
        if (sn_valid && d.tag_ok[s_set] && d.tag[s_set] == s_tag) begin
            d.vld[s_set][s_sec] = 1'b0;
            if (d.st == ST_FILL && d.fset == s_set && d.ftag == s_tag) begin
                d.kill[s_sec] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st     <= ST_IDLE;
            q.tag    <= '0;
            q.tag_ok <= '0;
            q.vld    <= '0;
            q.kill   <= '0;
            q.fset   <= '0;
            q.ftag   <= '0;
            q.fword  <= '0;
            q.fend   <= '0;
            q.resp   <= '0;
        end else begin
            q <= d;
        end
    end

    // ---------------- assertions
    // R3: refill beats walk upward one word at a time
    a_r3_fill_order: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FILL && mem_valid && mem_ready && d.st == ST_FILL)
        |=> (mem_addr == $past(mem_addr) + ADDR_W'(WORD_W / 8)));

    // R8: no completion towards the CPU while a refill beat is pending
    a_r8_cpu_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_we) |-> !cpu_ready);

    // R8: a refused beat keeps its address
    a_r8_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && mem_addr == $past(mem_addr)));

    // R4: a matching snoop leaves its sector invalid
    a_r4_snoop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (sn_valid && s_tag_hit) |=> !q.vld[$past(s_set)][$past(s_sec)]);

    // R9: every CPU write completes together with an accepted memory write
    a_r9_write_through: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && cpu_we && cpu_ready) |-> (mem_valid && mem_we && mem_ready));

    // R2: a read hit causes no memory traffic
    a_r2_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_req && !cpu_we && cpu_ready && cpu_hit) |-> !mem_valid);
endmodule

// File: tb/sect_cache_tb.sv
`timescale 1ns/1ps
module sect_cache_tb;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = 4;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           cpu_req, cpu_we;
    logic [AW-1:0]  cpu_addr;
    logic [DW-1:0]  cpu_wdata, cpu_rdata;
    logic           cpu_ready, cpu_hit;
    logic           mem_valid, mem_we, mem_ready;
    logic [AW-1:0]  mem_addr;
    logic [DW-1:0]  mem_wdata, mem_rdata;
    logic           sn_valid, pf_valid, pf_ready;
    logic [AW-1:0]  sn_addr, pf_addr;
    logic [SW*DW-1:0] pf_data;

    sect_cache u_dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata), .cpu_hit(cpu_hit),
        .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ready(mem_ready), .mem_rdata(mem_rdata),
        .sn_valid(sn_valid), .sn_addr(sn_addr),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_data(pf_data)
    );

    always #2 clk = ~clk;  // 250 MHz

    int checks = 0;
    int errors = 0;
    int rd_beats, wr_beats, order_err, stall_cyc;
    bit beat_any, stall_mode;
    logic [AW-1:0] first_addr, last_addr;

    function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
        logic [AW-1:0] w;
        w = {a[AW-1:2], 2'b00};
        return (w * 32'h9E37_79B1) ^ 32'h0000_5A5A;
    endfunction

    function automatic logic [DW-1:0] peer(input logic [AW-1:0] a);
        return {a[AW-1:2], 2'b00} ^ 32'hC0DE_0000;
    endfunction

    assign mem_rdata = pat(mem_addr);

    // memory ready pattern
    initial begin
        mem_ready = 1'b1;
        forever begin
            @(negedge clk);
            mem_ready <= stall_mode ? ~mem_ready : 1'b1;
        end
    end

    // beat monitor, sampled mid-cycle
    always @(negedge clk) begin
        #1;
        if (cpu_req && !cpu_ready) stall_cyc++;
        if (mem_valid && mem_ready) begin
            if (!mem_we) begin
                if (beat_any && mem_addr != last_addr + 32'd4) order_err++;
                if (!beat_any) first_addr = mem_addr;
                beat_any  = 1'b1;
                last_addr = mem_addr;
                rd_beats++;
            end else begin
                wr_beats++;
            end
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic cpu_op(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          output logic [DW-1:0] rd, output logic hit);
        beat_any  = 1'b0;
        rd_beats  = 0;
        wr_beats  = 0;
        stall_cyc = 0;
        @(negedge clk);
        cpu_req   = 1'b1;
        cpu_we    = we;
        cpu_addr  = a;
        cpu_wdata = wd;
        #1;
        while (!cpu_ready) begin
            @(negedge clk);
            #1;
        end
        rd  = cpu_rdata;
        hit = cpu_hit;
        @(negedge clk);
        cpu_req = 1'b0;
        cpu_we  = 1'b0;
    endtask

    task automatic snoop(input logic [AW-1:0] a);
        @(negedge clk);
        sn_valid = 1'b1;
        sn_addr  = a;
        @(negedge clk);
        sn_valid = 1'b0;
    endtask

    task automatic peer_fill(input logic [AW-1:0] a);
        @(negedge clk);
        pf_valid = 1'b1;
        pf_addr  = a;
        for (int i = 0; i < SW; i++) begin
            pf_data[i*DW +: DW] = peer({a[AW-1:4], 4'h0} + 32'(4 * i));
        end
        @(negedge clk);
        pf_valid = 1'b0;
    endtask

    // op: 0 read, 1 write, 2 snoop, 3 peer fill; src: 0 memory pattern, 1 literal, 2 peer pattern
    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] addr;
        logic [31:0] data;
        logic [1:0]  src;
        logic        hit;
        logic [4:0]  beats;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VEC [NV] = '{
        '{2'd0, 32'h0000_1040, 32'h0,         2'd0, 1'b0, 5'd16, 4'd3},  // R1 R3 cold block miss
        '{2'd0, 32'h0000_1074, 32'h0,         2'd0, 1'b1, 5'd0,  4'd3},  // R3 all sectors valid
        '{2'd0, 32'h0000_1058, 32'h0,         2'd0, 1'b1, 5'd0,  4'd2},  // R2 plain hit
        '{2'd2, 32'h0000_1054, 32'h0,         2'd0, 1'b0, 5'd0,  4'd4},  // R4 snoop sector 1
        '{2'd0, 32'h0000_1068, 32'h0,         2'd0, 1'b1, 5'd0,  4'd4},  // R4 sector 2 untouched
        '{2'd0, 32'h0000_1050, 32'h0,         2'd0, 1'b0, 5'd4,  4'd5},  // R5 sector refetch
        '{2'd0, 32'h0000_105C, 32'h0,         2'd0, 1'b1, 5'd0,  4'd5},  // R5 refetched sector hits
        '{2'd1, 32'h0000_1048, 32'hDEAD_BEEF, 2'd1, 1'b1, 5'd1,  4'd9},  // R9 write hit
        '{2'd0, 32'h0000_1048, 32'hDEAD_BEEF, 2'd1, 1'b1, 5'd0,  4'd9},  // R9 cached word updated
        '{2'd1, 32'h0000_2040, 32'h1111_2222, 2'd1, 1'b0, 5'd1,  4'd9},  // R9 write miss
        '{2'd0, 32'h0000_1048, 32'hDEAD_BEEF, 2'd1, 1'b1, 5'd0,  4'd9},  // R9 no allocation
        '{2'd0, 32'h0000_2044, 32'h0,         2'd0, 1'b0, 5'd16, 4'd10}, // R10 same set new tag
        '{2'd0, 32'h0000_1040, 32'h0,         2'd0, 1'b0, 5'd16, 4'd10}, // R10 old block replaced
        '{2'd0, 32'h0000_1080, 32'h0,         2'd0, 1'b0, 5'd16, 4'd10}, // R10 other set
        '{2'd0, 32'h0000_1044, 32'h0,         2'd0, 1'b1, 5'd0,  4'd10}, // R10 set 1 kept
        '{2'd3, 32'h0000_30E0, 32'h0,         2'd0, 1'b0, 5'd0,  4'd6},  // R6 peer fill sector 2
        '{2'd0, 32'h0000_30E8, 32'h0,         2'd2, 1'b1, 5'd0,  4'd6},  // R6 peer data hits
        '{2'd0, 32'h0000_30C4, 32'h0,         2'd0, 1'b0, 5'd4,  4'd6},  // R6 sector 0 missing
        '{2'd0, 32'h0000_30F0, 32'h0,         2'd0, 1'b0, 5'd4,  4'd6},  // R6 sector 3 missing
        '{2'd0, 32'h0000_30EC, 32'h0,         2'd2, 1'b1, 5'd0,  4'd6}   // R6 peer sector intact
    };

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        logic          hit;
        logic [DW-1:0] exp;
        string         tag;

        rst_n = 1'b0; cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0; cpu_wdata = '0;
        sn_valid = 1'b0; sn_addr = '0; pf_valid = 1'b0; pf_addr = '0; pf_data = '0;
        stall_mode = 1'b0; beat_any = 1'b0; order_err = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;

        // R1 reset state
        chk("R1", "cpu_ready idle", 32'(cpu_ready), 32'd0);
        chk("R1", "mem_valid idle", 32'(mem_valid), 32'd0);
        chk("R1", "pf_ready idle", 32'(pf_ready), 32'd1);

        // vector table
        for (int i = 0; i < NV; i++) begin
            tag = $sformatf("R%0d vec%0d", VEC[i].req, i);
            unique case (VEC[i].op)
                2'd0: begin
                    cpu_op(1'b0, VEC[i].addr, '0, rd, hit);
                    exp = (VEC[i].src == 2'd1) ? VEC[i].data :
                          (VEC[i].src == 2'd2) ? peer(VEC[i].addr) : pat(VEC[i].addr);
                    chk(tag, "read data", rd, exp);
                    chk(tag, "hit", 32'(hit), 32'(VEC[i].hit));
                    chk(tag, "read beats", 32'(rd_beats), 32'(VEC[i].beats));
                end
                2'd1: begin
                    cpu_op(1'b1, VEC[i].addr, VEC[i].data, rd, hit);
                    chk(tag, "hit", 32'(hit), 32'(VEC[i].hit));
                    chk(tag, "write beats", 32'(wr_beats), 32'(VEC[i].beats));
                    chk(tag, "read beats", 32'(rd_beats), 32'd0);
                end
                2'd2: snoop(VEC[i].addr);
                default: peer_fill(VEC[i].addr);
            endcase
        end
        chk("R3", "beat order errors", 32'(order_err), 32'd0);

        // R10 byte offset bits do not select a different word
        cpu_op(1'b0, 32'h0000_1047, '0, rd, hit);
        chk("R10", "byte offset data", rd, pat(32'h0000_1044));
        chk("R10", "byte offset hit", 32'(hit), 32'd1);

        // R8 refill with a memory that stalls every other cycle
        stall_mode = 1'b1;
        cpu_op(1'b0, 32'h0000_5008, '0, rd, hit);
        chk("R8", "stalled refill beats", 32'(rd_beats), 32'd16);
        chk("R8", "stalled refill data", rd, pat(32'h0000_5008));
        chk("R3", "refill starts at block base", first_addr, 32'h0000_5000);
        chk("R8", "cpu held long enough", 32'(stall_cyc >= 16), 32'd1);
        cpu_op(1'b1, 32'h0000_5004, 32'hA0A0_0505, rd, hit);
        chk("R8", "stalled write beats", 32'(wr_beats), 32'd1);
        chk("R9", "stalled write hit", 32'(hit), 32'd1);
        stall_mode = 1'b0;
        chk("R8", "beat order errors", 32'(order_err), 32'd0);

        // R7 snoop during refill of the same block
        fork
            cpu_op(1'b0, 32'h0000_4100, '0, rd, hit);
            begin
                @(negedge clk);
                wait (rd_beats >= 3);
                snoop(32'h0000_4120);
            end
        join
        chk("R7", "refill data", rd, pat(32'h0000_4100));
        chk("R7", "refill beats", 32'(rd_beats), 32'd16);
        cpu_op(1'b0, 32'h0000_4124, '0, rd, hit);
        chk("R7", "snooped sector misses", 32'(hit), 32'd0);
        chk("R7", "snooped sector refetch beats", 32'(rd_beats), 32'd4);
        cpu_op(1'b0, 32'h0000_4134, '0, rd, hit);
        chk("R7", "other sector hit", 32'(hit), 32'd1);
        chk("R7", "other sector data", rd, pat(32'h0000_4134));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule